// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two entries from a table held in memory. A request carries the virtual address and two access attributes: whether the access is a write, and whether it comes from user mode. The block takes the directory base from a control input that software reloads whenever the running process changes. The block samples that base once per request.

Once a request is accepted, the walker fetches a directory entry and then a page-table entry over a simple read port with one read in flight. It then returns the physical address or a fault. A fault shows whether the mapping was missing or the access was not allowed, and at which of the two levels this was found. Accesses from either privilege level go through the full walk. The block has no translation cache, so every request costs up to two memory reads.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.
- R2: The first read of a walk goes to the address `{base[31:12], va[31:22], 2'b00}`, where `base` is the directory base sampled when the request was accepted. Bits 11:0 of the base are ignored.
- R3: Every entry is 32 bits. Bit 0 means present, bit 1 means writable, bit 2 means user-accessible, and bits 31:12 hold a frame base. The second read goes to `{pde[31:12], va[21:12], 2'b00}`.
- R4: A walk with no fault returns `rsp_fault`=0 and `rsp_paddr = {pte[31:12], va[11:0]}`.
- R5: If the directory entry has bit 0 clear, the response has `rsp_fault`=1, `rsp_fault_prot`=0 and `rsp_fault_table`=0, and no second read is issued.
- R6: If the page-table entry has bit 0 clear, the response has `rsp_fault`=1, `rsp_fault_prot`=0 and `rsp_fault_table`=1.
- R7: A write is denied by a present entry with bit 1 clear. It then gets `rsp_fault_prot`=1, with `rsp_fault_table` set to 0 if the directory entry denied it or 1 if the page-table entry did. A denying directory entry ends the walk after one read.
- R8: A user access is denied in the same way by an entry with bit 2 clear. Supervisor accesses ignore bit 2.
- R9: Every response carries the request's virtual address on `rsp_vaddr`. On a fault, `rsp_paddr` is 0.
- R10: `req_ready` is 0 from acceptance until the response. A request presented in that time is ignored: it causes no read and no response.
- R11: While `mem_rd_en` is 1 and `mem_rvalid` has not arrived, `mem_rd_en` and `mem_addr` hold steady. Any read latency is accepted.
- R12: `rsp_valid` is a single-cycle pulse in the cycle after the read data that ends the walk.
- R13: A change of `dir_base` during a walk does not affect that walk. The next request uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| dir_base | input | 32 | Page directory base of the running process |
| mem_rd_en | output | 1 | Read request to memory |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_vaddr | output | 32 | Virtual address of the finished request |
| rsp_fault | output | 1 | Translation failed |
| rsp_fault_prot | output | 1 | 1 = permission denied, 0 = not present |
| rsp_fault_table | output | 1 | 1 = found at the page-table level, 0 = at the directory level |

## Verification
If the latched state were wrong, the read addresses would show it first. A bad index or a stale base reaches `mem_addr` in the first read cycle after acceptance. A bad frame latch shows in the second read cycle. A misrouted fault decision shows one cycle after the deciding read data, as a wrong fault kind or level. It also shows as a second read that should not happen, or as a missing one. A state machine that fails to return to idle shows at once as `req_ready` staying low and the next request getting no response.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  input  logic [31:0] dir_base,
  output logic        mem_rd_en,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic [31:0] rsp_vaddr,
  output logic        rsp_fault,
  output logic        rsp_fault_prot,
  output logic        rsp_fault_table
);

  typedef enum logic [1:0] {S_IDLE, S_PDE, S_PTE, S_DONE} walk_t;

  walk_t       state;
  logic [31:0] va_q;
  logic        wr_q, usr_q;
  logic [19:0] base_q;
  logic [19:0] frame_q;
  logic [31:0] paddr_q;
  logic        fault_q, prot_q, tbl_q;

  logic entry_absent, entry_denied;
  assign entry_absent = !mem_rdata[0];
  assign entry_denied = (wr_q && !mem_rdata[1]) || (usr_q && !mem_rdata[2]);

  logic unused_bits;
  assign unused_bits = ^{mem_rdata[11:3], dir_base[11:0]};

  assign req_ready = (state == S_IDLE);
  assign mem_rd_en = (state == S_PDE) || (state == S_PTE);
  assign mem_addr  = (state == S_PTE) ? {frame_q, va_q[21:12], 2'b00}
                                      : {base_q,  va_q[31:22], 2'b00};

  assign rsp_valid       = (state == S_DONE);
  assign rsp_paddr       = paddr_q;
  assign rsp_vaddr       = va_q;
  assign rsp_fault       = fault_q;
  assign rsp_fault_prot  = prot_q;
  assign rsp_fault_table = tbl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      base_q  <= '0;
      frame_q <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      prot_q  <= 1'b0;
      tbl_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          usr_q  <= req_user;
          base_q <= dir_base[31:12];
          state  <= S_PDE;
        end
        S_PDE: if (mem_rvalid) begin
          if (entry_absent || entry_denied) begin
            fault_q <= 1'b1;
            prot_q  <= !entry_absent;
            tbl_q   <= 1'b0;
            paddr_q <= '0;
            state   <= S_DONE;
          end else begin
            frame_q <= mem_rdata[31:12];
            state   <= S_PTE;
          end
        end
        S_PTE: if (mem_rvalid) begin
          fault_q <= entry_absent || entry_denied;
          prot_q  <= !entry_absent && entry_denied;
          tbl_q   <= entry_absent || entry_denied;
          paddr_q <= (entry_absent || entry_denied) ? 32'h0 : {mem_rdata[31:12], va_q[11:0]};
          state   <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_read_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_rvalid) |=> (mem_rd_en && $stable(mem_addr)));

  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_after_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(mem_rvalid));

  assert_idle_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && mem_rd_en));

  assert_pde_absent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PDE && mem_rvalid && !mem_rdata[0]) |=>
      (rsp_valid && rsp_fault && !rsp_fault_prot && !rsp_fault_table));

  assert_fault_no_paddr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'h0));

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, req_user;
  logic [31:0] req_vaddr, dir_base, mem_addr, mem_rdata, rsp_paddr, rsp_vaddr;
  logic        mem_rd_en, mem_rvalid, rsp_valid, rsp_fault, rsp_fault_prot, rsp_fault_table;

  pt_walker u_pt_walker (.*);

  int checks = 0, fails = 0, cycles = 0;
  int lat = 0, cnt = 0, nreads = 0;
  logic [31:0] log_addr [256];
  logic [31:0] mem [int unsigned];

  function automatic logic [31:0] lookup(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0; mem_rdata <= '0; cnt <= 0;
    end else if (mem_rvalid) begin
      mem_rvalid <= 1'b0; cnt <= 0;
    end else if (mem_rd_en) begin
      if (cnt >= lat) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= lookup(mem_addr);
        log_addr[nreads[7:0]] <= mem_addr;
        nreads <= nreads + 1;
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      finish_run();
    end
  end

  task automatic issue(logic [31:0] va, logic wr, logic usr);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(string tag);
    int n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    chk({tag, " response arrives"}, {31'b0, rsp_valid}, 32'd1);
  endtask

  task automatic translate(string tag, logic [31:0] va, logic wr, logic usr,
                           logic f, logic p, logic t, logic [31:0] pa, int reads);
    int start = nreads;
    issue(va, wr, usr);
    wait_rsp(tag);
    chk({tag, " fault"}, {31'b0, rsp_fault}, {31'b0, f});
    chk({tag, " kind"}, {31'b0, rsp_fault_prot}, {31'b0, p});
    chk({tag, " level"}, {31'b0, rsp_fault_table}, {31'b0, t});
    chk({tag, " paddr"}, rsp_paddr, pa);
    chk({tag, " vaddr R9"}, rsp_vaddr, va);
    chk({tag, " read count"}, nreads - start, reads);
    @(negedge clk);
    chk({tag, " pulse R12"}, {31'b0, rsp_valid}, 32'd0);
    chk({tag, " ready again R10"}, {31'b0, req_ready}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 ready", {31'b0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 rd_en", {31'b0, mem_rd_en}, 32'd0);
  endtask

  task automatic t_hit();
    int s = nreads;
    lat = 0;
    translate("R4 hit", 32'h0040_3ABC, 0, 1, 0, 0, 0, 32'h0ABC_DABC, 2);
    chk("R2 pde addr", log_addr[s[7:0]], 32'h0001_0004);
    chk("R3 pte addr", log_addr[s[7:0] + 8'd1], 32'h0002_000C);
  endtask

  task automatic t_latency();
    lat = 3;
    translate("R11 slow hit", 32'h0040_3ABC, 1, 0, 0, 0, 0, 32'h0ABC_DABC, 2);
    lat = 0;
  endtask

  task automatic t_absent();
    int s = nreads;
    translate("R5 pde absent", 32'h0080_0000, 0, 0, 1, 0, 0, 32'h0, 1);
    chk("R5 pde addr", log_addr[s[7:0]], 32'h0001_0008);
    translate("R6 pte absent", 32'h0040_7000, 0, 0, 1, 0, 1, 32'h0, 2);
  endtask

  task automatic t_protect();
    translate("R7 write ro pte", 32'h0040_5123, 1, 1, 1, 1, 1, 32'h0, 2);
    translate("R7 read ro pte", 32'h0040_5123, 0, 1, 0, 0, 0, 32'h0033_3123, 2);
    translate("R7 write ro pde", 32'h00C0_1000, 1, 0, 1, 1, 0, 32'h0, 1);
    translate("R8 user sup pte", 32'h0040_6010, 0, 1, 1, 1, 1, 32'h0, 2);
    translate("R8 sup write sup pte", 32'h0040_6010, 1, 0, 0, 0, 0, 32'h0044_4010, 2);
  endtask

  task automatic t_busy();
    int s = nreads;
    issue(32'h0040_3ABC, 0, 0);
    req_valid = 1'b1; req_vaddr = 32'h0080_0000;
    #1 chk("R10 busy ready low", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp("R10 busy");
    chk("R10 busy paddr", rsp_paddr, 32'h0ABC_DABC);
    chk("R10 busy vaddr", rsp_vaddr, 32'h0040_3ABC);
    repeat (6) @(negedge clk);
    chk("R10 ignored request no reads", nreads - s, 2);
    chk("R10 ignored request no rsp", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_base();
    int s = nreads;
    issue(32'h0040_3ABC, 0, 0);
    dir_base = 32'h0005_0FFF;
    wait_rsp("R13 old base");
    chk("R13 old base pde addr", log_addr[s[7:0]], 32'h0001_0004);
    chk("R13 old base paddr", rsp_paddr, 32'h0ABC_DABC);
    @(negedge clk);
    s = nreads;
    translate("R13 new base", 32'h0040_3ABC, 0, 0, 0, 0, 0, 32'h0777_7ABC, 2);
    chk("R2 low base bits ignored", log_addr[s[7:0]], 32'h0005_0004);
  endtask

  initial begin
    mem[32'h0001_0004] = 32'h0002_0007;
    mem[32'h0002_000C] = 32'h0ABC_D007;
    mem[32'h0002_0014] = 32'h0033_3005;
    mem[32'h0002_0018] = 32'h0044_4003;
    mem[32'h0001_000C] = 32'h0003_0005;
    mem[32'h0005_0004] = 32'h0006_0007;
    mem[32'h0006_000C] = 32'h0777_7007;
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    req_user = 1'b0; dir_base = 32'h0001_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit();
    t_latency();
    t_absent();
    t_protect();
    t_busy();
    t_base();
    finish_run();
  end
endmodule